// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block turns a running, already-corrected nanosecond time value into up to three trains of single-cycle pulses whose phase is fixed by a programmed start instant. The time input comes with an advance strobe and the number of nanoseconds each advance adds. A 64-bit alarm value is compared against the time. When the alarm is reached and starting on the alarm is enabled, every pulse generator loads its interval and begins counting. Each generator then emits a pulse once per programmed period. A companion strobe follows each pulse of generator 0 by one cycle. The strobe can raise an interrupt or feed a one-pulse-per-second event.

Software computes the start instant from the current time. It picks the next whole second that lies at least half a second ahead, subtracts one tick, and writes the result as the alarm. Each interval register receives the wanted period minus one tick. After any step of the time base, software writes the alarm and the intervals again. This stops the trains and restarts them on the new second boundary.

The alarm sequencer has three states. IDLE means no alarm is armed. ARMED means it is waiting for the time to reach the alarm. RUN means the generators are counting. A write of the alarm's upper half moves any state to ARMED. When the alarm is reached in ARMED, the sequencer goes to RUN if the start-on-alarm bit is set and to IDLE if it is clear. IDLE and RUN otherwise hold.

Top module: `alarm_pulse_gen`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, every pulse line and the event strobe are low and the sequencer is in IDLE.
- R2: The alarm is one 64-bit value written in two halves: address 0 sets bits 31:0 and address 1 sets bits 63:32. A write to address 0 alone does not arm the alarm. A write to address 1 arms it, and the comparison covers all 64 bits.
- R3: While armed, the alarm is reached in any cycle where the time input is greater than or equal to the alarm. This holds even when the time jumps past the alarm without ever equalling it. The alarm fires once. A later match has no effect until address 1 is written again.
- R4: Bit 0 of the control register (address 2) is the start-on-alarm enable. If it is clear when the alarm is reached, no generator starts, and setting it afterwards starts nothing.
- R5: Generator g has its interval at address 3+g. On start it loads the interval into a remaining count. On each advance after that, one of two things happens. If the count is no greater than the tick, the generator raises its pulse line for one cycle and adds the interval to the count. Otherwise it subtracts the tick. The pulse appears in the cycle after the advance that caused it.
- R6: A generator whose interval register holds zero emits no pulses.
- R7: The third generator exists only when parameter THIRD_EN is 1. Otherwise pulse line 2 stays low and writes to address 5 have no effect.
- R8: The event strobe is high for exactly the cycle after each pulse of generator 0 and at no other time.
- R9: Writing address 1 while the generators run stops them until the new alarm is reached. They then restart from their current interval values.
- R10: Cycles without an advance strobe change no remaining count and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| time_ns_i | input | 64 | Corrected time in nanoseconds |
| tick_adv_i | input | 1 | Time advanced by one tick this cycle |
| tick_ns_i | input | 8 | Nanoseconds per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0/1 alarm halves, 2 control, 3..5 intervals) |
| wr_data_i | input | 32 | Register write data |
| pulse_o | output | 3 | One-cycle pulse per generator |
| pulse_evt_o | output | 1 | Event strobe following generator 0's pulse |

## Verification
The bench aims at four corner cases. The first is an alarm just past a 32-bit boundary, where a design comparing only the low half starts billions of nanoseconds early. The second is a time jump past the alarm, which an equality comparator would miss forever. The third is a match while start-on-alarm is clear, after which a design that keeps the alarm pending wrongly starts once the bit is set. The fourth is the carry of the remainder into each reload: a design that reloads without the leftover count drifts one tick per period and fails the exact pulse counts. Zero intervals, stalled advances and the two-generator build are also exercised, and a cycle-by-cycle reference model is compared against every output under random ticks, intervals and advance patterns.

// File: rtl/apg_pkg.sv
package apg_pkg;
    localparam int MAX_GEN      = 3;
    localparam int REG_ALARM_LO = 0;
    localparam int REG_ALARM_HI = 1;
    localparam int REG_CTRL     = 2;
    localparam int REG_IVL0     = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/apg_alarm_seq.sv
module apg_alarm_seq
    import apg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    localparam int TIME_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [TIME_W-1:0] time_ns_i,
    output logic              start_o,
    output logic              run_o,
    output seq_state_e        state_o
);
    logic [TIME_W-1:0] alarm_q;
    logic              start_en_q;
    seq_state_e        state_q, state_d;
    logic              lo_wr, hi_wr, ctrl_wr, reached;

    assign lo_wr   = wr_en_i && (wr_addr_i == ADDR_W'(REG_ALARM_LO));
    assign hi_wr   = wr_en_i && (wr_addr_i == ADDR_W'(REG_ALARM_HI));
    assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(REG_CTRL));
    assign reached = (time_ns_i >= alarm_q);

    // alarm halves and start-on-alarm enable
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            alarm_q    <= '0;
            start_en_q <= 1'b0;
        end else begin
            if (lo_wr)   alarm_q[DATA_W-1:0]      <= wr_data_i;
            if (hi_wr)   alarm_q[TIME_W-1:DATA_W] <= wr_data_i;
            if (ctrl_wr) start_en_q               <= wr_data_i[0];
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (hi_wr) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: if (reached) state_d = start_en_q ? ST_RUN : ST_IDLE;
                ST_RUN:   state_d = ST_RUN;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        start_o = (state_q == ST_ARMED) && !hi_wr && reached && start_en_q;
        run_o   = (state_q == ST_RUN);
        state_o = state_q;
    end
endmodule

// File: rtl/apg_pulse_gen.sv
module apg_pulse_gen #(
    parameter int DATA_W    = 32,
    parameter int TICK_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int SLOT_ADDR = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              start_i,
    input  logic              run_i,
    input  logic              adv_i,
    input  logic [TICK_W-1:0] tick_i,
    output logic              pulse_o,
    output logic [DATA_W-1:0] ivl_o
);
    localparam int REM_W = DATA_W + 1;

    logic [DATA_W-1:0] ivl_q;
    logic [REM_W-1:0]  rem_q;
    logic              pulse_q;
    logic              ivl_wr, active, due;
    logic [REM_W-1:0]  tick_ext;

    assign ivl_wr   = wr_en_i && (wr_addr_i == ADDR_W'(SLOT_ADDR));
    assign tick_ext = REM_W'(tick_i);
    assign active   = run_i && adv_i && (ivl_q != '0);
    assign due      = (rem_q <= tick_ext);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ivl_q   <= '0;
            rem_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (ivl_wr) ivl_q <= wr_data_i;
            if (start_i) begin
                rem_q <= {1'b0, ivl_q};
            end else if (active) begin
                if (due) begin
                    pulse_q <= 1'b1;
                    rem_q   <= rem_q + {1'b0, ivl_q};
                end else begin
                    rem_q   <= rem_q - tick_ext;
                end
            end
        end
    end

    assign pulse_o = pulse_q;
    assign ivl_o   = ivl_q;
endmodule

// File: rtl/alarm_pulse_gen.sv
module alarm_pulse_gen
    import apg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int TICK_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int THIRD_EN = 1,
    localparam int TIME_W  = 2 * DATA_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [TIME_W-1:0]  time_ns_i,
    input  logic               tick_adv_i,
    input  logic [TICK_W-1:0]  tick_ns_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [MAX_GEN-1:0] pulse_o,
    output logic               pulse_evt_o
);
    localparam int NUM_GEN = (THIRD_EN != 0) ? MAX_GEN : MAX_GEN - 1;

    seq_state_e                seq_state;
    logic                      seq_start, seq_run;
    logic [MAX_GEN-1:0]        pulse_w;
    logic [MAX_GEN*DATA_W-1:0] ivl_all;
    logic                      evt_q;

    apg_alarm_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .time_ns_i (time_ns_i),
        .start_o   (seq_start),
        .run_o     (seq_run),
        .state_o   (seq_state)
    );

    for (genvar g = 0; g < MAX_GEN; g++) begin : g_gen
        if (g < NUM_GEN) begin : g_on
            apg_pulse_gen #(
                .DATA_W(DATA_W), .TICK_W(TICK_W), .ADDR_W(ADDR_W),
                .SLOT_ADDR(REG_IVL0 + g)
            ) u_gen (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .wr_en_i   (wr_en_i),
                .wr_addr_i (wr_addr_i),
                .wr_data_i (wr_data_i),
                .start_i   (seq_start),
                .run_i     (seq_run),
                .adv_i     (tick_adv_i),
                .tick_i    (tick_ns_i),
                .pulse_o   (pulse_w[g]),
                .ivl_o     (ivl_all[g*DATA_W +: DATA_W])
            );
        end else begin : g_off
            assign pulse_w[g]                 = 1'b0;
            assign ivl_all[g*DATA_W +: DATA_W] = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) evt_q <= 1'b0;
        else         evt_q <= pulse_w[0];
    end

    assign pulse_o     = pulse_w;
    assign pulse_evt_o = evt_q;
endmodule

// File: rtl/alarm_pulse_gen_checker.sv
module alarm_pulse_gen_checker
    import apg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int THIRD  = 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      adv,
    input seq_state_e                state,
    input logic [MAX_GEN-1:0]        pulse,
    input logic                      evt,
    input logic [MAX_GEN*DATA_W-1:0] ivl_all
);
    assert_pulse_needs_adv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |-> $past(adv));

    assert_pulse_only_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |-> $past(state == ST_RUN));

    assert_run_from_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> $past(state == ST_ARMED));

    assert_evt_after_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse[0] |=> evt);

    assert_evt_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(pulse[0]));

    for (genvar g = 0; g < MAX_GEN; g++) begin : g_zero
        assert_zero_ivl_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ivl_all[g*DATA_W +: DATA_W]) == '0) |-> !pulse[g]);
    end

    if (THIRD == 0) begin : g_two
        assert_third_absent_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !pulse[MAX_GEN-1]);
    end
endmodule

bind alarm_pulse_gen alarm_pulse_gen_checker #(.DATA_W(DATA_W), .THIRD(THIRD_EN)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .adv     (tick_adv_i),
    .state   (seq_state),
    .pulse   (pulse_w),
    .evt     (evt_q),
    .ivl_all (ivl_all)
);

// File: tb/alarm_pulse_gen_test.sv
module alarm_pulse_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_ns = '0;
    logic        adv = 1'b0;
    logic [7:0]  tick = 8'd8;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  pulse, pulse2;
    logic        evt, evt2;

    always #10 clk = ~clk;

    alarm_pulse_gen uut (
        .clk_i(clk), .rst_ni(rst_n), .time_ns_i(time_ns), .tick_adv_i(adv),
        .tick_ns_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pulse_o(pulse), .pulse_evt_o(evt)
    );

    alarm_pulse_gen #(.THIRD_EN(0)) uut2 (
        .clk_i(clk), .rst_ni(rst_n), .time_ns_i(time_ns), .tick_adv_i(adv),
        .tick_ns_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pulse_o(pulse2), .pulse_evt_o(evt2)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R5";
    int    cnt [3];

    // reference model state
    int          mstate = 0;
    logic [63:0] malarm = '0;
    logic        mctrl = 1'b0;
    logic [31:0] mivl [3];
    logic [32:0] mrem [3];
    logic [2:0]  mpulse = '0;
    logic        mevt = 1'b0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic hiw   = wr_en && (wr_addr == 3'd1);
        logic match = (time_ns >= malarm);
        logic start = (mstate == 1) && !hiw && match && mctrl;
        int   nst   = mstate;
        mevt = mpulse[0];
        if (hiw) nst = 1;
        else if (mstate == 1 && match) nst = mctrl ? 2 : 0;
        for (int g = 0; g < 3; g++) begin
            mpulse[g] = 1'b0;
            if (start) mrem[g] = {1'b0, mivl[g]};
            else if (mstate == 2 && adv && mivl[g] != 0) begin
                if (mrem[g] <= {25'd0, tick}) begin
                    mpulse[g] = 1'b1;
                    mrem[g]   = mrem[g] + {1'b0, mivl[g]};
                end else begin
                    mrem[g] = mrem[g] - {25'd0, tick};
                end
            end
        end
        if (wr_en) begin
            case (wr_addr)
                3'd0: malarm[31:0]  = wr_data;
                3'd1: malarm[63:32] = wr_data;
                3'd2: mctrl         = wr_data[0];
                3'd3, 3'd4, 3'd5: mivl[wr_addr - 3'd3] = wr_data;
                default: ;
            endcase
        end
        mstate = nst;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(cur_req, "pulse", 32'(pulse), 32'(mpulse));
        check("R8", "event", 32'(evt), 32'(mevt));
        check("R7", "pulse two-gen build", 32'(pulse2), {30'd0, mpulse[1:0]});
        check("R7", "event two-gen build", 32'(evt2), 32'(mevt));
        for (int g = 0; g < 3; g++) cnt[g] += int'(pulse[g]);
        wr_en = 1'b0;
        if (adv) time_ns = time_ns + 64'(tick);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        adv = 1'b0;
        cyc();
    endtask

    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            adv = (mode == 1) ? 1'b1 : (mode == 0) ? 1'b0 : 1'($urandom % 2);
            cyc();
        end
    endtask

    task automatic clr();
        for (int g = 0; g < 3; g++) cnt[g] = 0;
    endtask

    task automatic arm(input logic [63:0] a);
        wr(3'd0, a[31:0]);
        wr(3'd1, a[63:32]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int g = 0; g < 3; g++) begin mivl[g] = '0; mrem[g] = '0; end
        clr();
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1", "pulse in reset", 32'(pulse), 0);
        check("R1", "event in reset", 32'(evt), 0);
        rst_n = 1'b1;
        cur_req = "R1";
        run(2, 1);

        // setup: intervals 72 and 152, third zero (R6), start-on-alarm on
        cur_req = "R5";
        tick = 8'd8; time_ns = 64'd1000;
        wr(3'd3, 32'd72); wr(3'd4, 32'd152); wr(3'd5, 32'd0); wr(3'd2, 32'd1);

        // R2: low half alone does not arm
        cur_req = "R2";
        wr(3'd0, 32'd500);
        clr(); run(60, 1);
        check("R2", "pulses after low-half write only", 32'(cnt[0] + cnt[1]), 0);

        // R5: arm with a past alarm, start on the next cycle, count exact pulses
        cur_req = "R5";
        wr(3'd1, 32'd0);
        adv = 1'b0; cyc();           // start cycle
        clr(); run(100, 1);
        check("R5", "gen0 pulses in 100 advances, interval 72 tick 8", 32'(cnt[0]), 10);
        check("R5", "gen1 pulses in 100 advances, interval 152 tick 8", 32'(cnt[1]), 5);
        check("R6", "gen2 pulses with zero interval", 32'(cnt[2]), 0);

        // R10: no advances, no pulses
        cur_req = "R10";
        clr(); run(50, 0);
        check("R10", "pulses without advance", 32'(cnt[0] + cnt[1]), 0);

        // R9: rearm into the future stops the trains
        cur_req = "R9";
        arm(time_ns + 64'd100000);
        clr(); run(60, 1);
        check("R9", "pulses while waiting for new alarm", 32'(cnt[0] + cnt[1]), 0);

        // R3: jump past the alarm without equality
        cur_req = "R3";
        time_ns = time_ns + 64'd200003;
        adv = 1'b0; cyc();
        clr(); run(100, 1);
        check("R3", "gen0 pulses after time jump past alarm", 32'(cnt[0]), 10);

        // R4: match with start disabled, then enable: nothing starts
        cur_req = "R4";
        wr(3'd2, 32'd0);
        arm(64'd0);
        clr(); run(80, 1);
        check("R4", "pulses after match with start clear", 32'(cnt[0] + cnt[1]), 0);
        wr(3'd2, 32'd1);
        clr(); run(80, 1);
        check("R3", "pulses after enabling without rearm", 32'(cnt[0] + cnt[1]), 0);

        // R2: 64-bit compare across the 32-bit boundary
        cur_req = "R2";
        time_ns = 64'h0000_0000_FFFF_FF00;
        wr(3'd5, 32'd40);
        arm(64'h0000_0001_0000_0010);
        clr(); run(25, 1);
        check("R2", "pulses before upper-half alarm reached", 32'(cnt[0] + cnt[1] + cnt[2]), 0);
        run(120, 1);
        check("R2", "gen2 pulses after upper-half alarm", 32'(cnt[2] > 0), 1);

        // random phase checked cycle by cycle against the model
        cur_req = "R5";
        for (int r = 0; r < 20; r++) begin
            tick = 8'(1 + $urandom % 16);
            for (int g = 0; g < 3; g++)
                wr(3'(3 + g), ($urandom % 5 == 0) ? 32'd0 : 32'(10 + $urandom % 200));
            wr(3'd2, ($urandom % 4 == 0) ? 32'd0 : 32'd1);
            arm(time_ns + 64'($urandom % 400));
            run(300, 2);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule